// File: doc/BRIEF.md
# MESIF Line Coherence Controller

This block keeps one tracked memory line coherent across a small group of private caches. It uses five states: Modified, Exclusive, Shared, Invalid and Forward. Each core presents read and write requests for the line. The controller acts as the shared snooping channel. It accepts one request per cycle, chooses the bus operation, and works out every other cache's snoop response in the same cycle: whether that cache supplies data, writes back, or is invalidated. It then updates the state of every cache.

The Forward state means that a read miss is answered by exactly one clean cache, the most recent reader, instead of by every sharer. A write that needs other copies removed sends invalidations to those caches. The writer reaches Modified only after every one of them has acknowledged, and no other request is accepted while it waits.

Top module: `mesif_line_ctrl`

## Requirements
- R1: After reset every cache is Invalid (state code 0), no grant is given, and `busy_o` is low. State codes are I=0, S=1, E=2, M=3, F=4.
- R2: A read from an Invalid cache while no other cache holds the line issues bus op 1 (read). Memory supplies the data (`mem_supply_o`=1) and the requester becomes E. Bus op codes are none=0, read=1, read-for-ownership=2, upgrade=3.
- R3: A read miss while another cache holds the line in M, E or F makes exactly that cache supply the data (its `supply_o` bit). That cache drops to S, the requester becomes F, and memory does not supply. Shared holders stay silent.
- R4: On a read miss that hits a Modified copy, the owner raises its `wb_o` bit and afterwards no longer holds M.
- R5: At most one cache is in F at any time. A cache in M or E is the only valid copy.
- R6: A write from E moves to M with bus op 0. A write from M produces bus op 0 and no snoop activity.
- R7: A write from S or F issues bus op 3 and raises `inv_o` for every other valid copy, which go Invalid. The writer keeps its state until every target has acknowledged on `inv_ack_i`, then becomes M and `busy_o` drops. Acknowledgements from caches that are not targets are ignored.
- R8: A write from I issues bus op 2. A Modified holder writes back (`wb_o`) and goes Invalid along with all other copies. The requester becomes M after the targets acknowledge, or at once if there are none.
- R9: While `busy_o` is high no request is granted. When several cores request at once, the lowest index is granted. An ungranted core that keeps requesting is served later.
- R10: A read from a cache already holding the line gives bus op 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | NCACHE | Per-core request, held until granted |
| req_wr_i | input | NCACHE | Per-core request is a write |
| inv_ack_i | input | NCACHE | Per-cache invalidation acknowledge |
| grant_o | output | NCACHE | One-hot request accepted this cycle |
| bus_op_o | output | 2 | Bus operation of the granted request |
| supply_o | output | NCACHE | Snoop response: this cache supplies data |
| mem_supply_o | output | 1 | Memory supplies the read data |
| wb_o | output | NCACHE | Writeback strobe per cache |
| inv_o | output | NCACHE | Invalidation sent to this cache |
| busy_o | output | 1 | Waiting for invalidation acknowledgements |
| state_o | output | 3*NCACHE | Per-cache line state, cache k at bits 3k+2..3k |

## Verification
The assertions check the following on every cycle: the ownership invariant (M or E only as the sole valid copy), that at most one cache is in F, that at most one data source answers a read, that grants stop while the controller waits, that a writeback leaves no M copy behind, and that a writer never reaches M while acknowledgements are still outstanding. The bench scenarios show what only a sequence of requests can expose. These are where Forward moves between readers, the exact bus op and snoop masks for each state combination, that stray acknowledgements are ignored, the lowest-index grant order, and that a request blocked during an invalidation is served once the wait ends.

// File: rtl/mesif_pkg.sv
package mesif_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_M = 3'd3, ST_F = 3'd4
  } lstate_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0, OP_RD = 2'd1, OP_RDX = 2'd2, OP_UPG = 2'd3
  } busop_t;

  // Bus operation a request needs, given the requester's own state.
  function automatic logic [1:0] op_for(input logic [2:0] s, input logic wr);
    if (!wr) return (s == ST_I) ? OP_RD : OP_NONE;
    if (s == ST_M || s == ST_E) return OP_NONE;
    return (s == ST_I) ? OP_RDX : OP_UPG;
  endfunction

  // A cache answering a read with data: the single clean forwarder or an owner.
  function automatic logic can_supply(input logic [2:0] s);
    return (s == ST_M) || (s == ST_E) || (s == ST_F);
  endfunction

  // State a read-miss requester takes.
  function automatic logic [2:0] fill_state(input logic shared);
    return shared ? ST_F : ST_E;
  endfunction
endpackage

// File: rtl/mesif_arb.sv
module mesif_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Fixed priority: lowest index wins, scan from the top so it overrides.
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (en && req[k]) begin
        gnt    = '0;
        gnt[k] = 1'b1;
        idx    = IW'(k);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mesif_snoop.sv
module mesif_snoop
  import mesif_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][2:0] st,
  input  logic [IW-1:0]     ridx,
  input  logic [1:0]        op,
  output logic [N-1:0][2:0] nxt,
  output logic [N-1:0]      supply,
  output logic [N-1:0]      wb,
  output logic [N-1:0]      inv,
  output logic              others_valid
);
  logic [N-1:0] peer_valid;

  for (genvar k = 0; k < N; k++) begin : g_cache
    logic       is_peer;
    logic [2:0] n_k;
    logic       s_k, w_k, i_k;

    assign is_peer       = (ridx != IW'(k));
    assign peer_valid[k] = is_peer && (st[k] != ST_I);

    always_comb begin
      n_k = st[k];
      s_k = 1'b0;
      w_k = 1'b0;
      i_k = 1'b0;
      case (op)
        OP_RD: if (is_peer && can_supply(st[k])) begin
          s_k = 1'b1;
          w_k = (st[k] == ST_M);
          n_k = ST_S;
        end
        OP_RDX, OP_UPG: if (peer_valid[k]) begin
          i_k = 1'b1;
          w_k = (st[k] == ST_M);
          n_k = ST_I;
        end
        default: ;
      endcase
    end

    assign nxt[k]    = n_k;
    assign supply[k] = s_k;
    assign wb[k]     = w_k;
    assign inv[k]    = i_k;
  end

  assign others_valid = |peer_valid;
endmodule

// File: rtl/mesif_line_ctrl.sv
module mesif_line_ctrl
  import mesif_pkg::*;
#(
  parameter int NCACHE = 4,
  localparam int IW = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCACHE-1:0]     req_vld_i,
  input  logic [NCACHE-1:0]     req_wr_i,
  input  logic [NCACHE-1:0]     inv_ack_i,
  output logic [NCACHE-1:0]     grant_o,
  output logic [1:0]            bus_op_o,
  output logic [NCACHE-1:0]     supply_o,
  output logic                  mem_supply_o,
  output logic [NCACHE-1:0]     wb_o,
  output logic [NCACHE-1:0]     inv_o,
  output logic                  busy_o,
  output logic [3*NCACHE-1:0]   state_o
);
  logic [NCACHE-1:0][2:0] st_q, st_d, snp_nxt;
  logic                   busy_q, busy_d;
  logic [NCACHE-1:0]      pend_q, pend_d, pend_left;
  logic [IW-1:0]          widx_q, widx_d;
  logic [IW-1:0]          gidx;
  logic                   gany, others_valid;
  logic [1:0]             cur_op;

  mesif_arb #(.N(NCACHE)) arb_i (
    .req(req_vld_i), .en(!busy_q), .gnt(grant_o), .idx(gidx), .any(gany)
  );

  assign cur_op = gany ? op_for(st_q[gidx], req_wr_i[gidx]) : OP_NONE;

  mesif_snoop #(.N(NCACHE)) snoop_i (
    .st(st_q), .ridx(gidx), .op(cur_op), .nxt(snp_nxt),
    .supply(supply_o), .wb(wb_o), .inv(inv_o), .others_valid(others_valid)
  );

  assign pend_left    = pend_q & ~inv_ack_i;
  assign mem_supply_o = (cur_op == OP_RD) && (supply_o == '0);
  assign bus_op_o     = cur_op;
  assign busy_o       = busy_q;
  assign state_o      = st_q;

  always_comb begin
    st_d   = st_q;
    busy_d = busy_q;
    pend_d = pend_q;
    widx_d = widx_q;
    if (busy_q) begin
      pend_d = pend_left;
      if (pend_left == '0) begin
        st_d[widx_q] = ST_M;
        busy_d       = 1'b0;
      end
    end else if (gany) begin
      for (int k = 0; k < NCACHE; k++)
        if (IW'(k) != gidx) st_d[k] = snp_nxt[k];
      case (cur_op)
        OP_RD: st_d[gidx] = fill_state(others_valid);
        OP_RDX, OP_UPG: begin
          if (inv_o == '0) st_d[gidx] = ST_M;
          else begin
            busy_d = 1'b1;
            pend_d = inv_o;
            widx_d = gidx;
          end
        end
        default: if (req_wr_i[gidx]) st_d[gidx] = ST_M;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      busy_q <= 1'b0;
      pend_q <= '0;
      widx_q <= '0;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
      pend_q <= pend_d;
      widx_q <= widx_d;
    end
  end

  // ---------------- assertions ----------------
  logic [NCACHE-1:0] m_mask, e_mask, f_mask, v_mask;
  for (genvar k = 0; k < NCACHE; k++) begin : g_mask
    assign m_mask[k] = (st_q[k] == ST_M);
    assign e_mask[k] = (st_q[k] == ST_E);
    assign f_mask[k] = (st_q[k] == ST_F);
    assign v_mask[k] = (st_q[k] != ST_I);

    a_r4_wb_leaves_m: assert property (@(posedge clk) disable iff (!rst_n)
      wb_o[k] |=> (st_q[k] != ST_M));
  end

  a_r5_sole_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_mask | e_mask)) |-> ($countones(v_mask) == 1));

  a_r5_one_forward: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_mask));

  a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(supply_o) && !(mem_supply_o && (supply_o != '0)));

  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (grant_o == '0));

  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r7_wait_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (pend_left != '0)) |=> (busy_q && (st_q[widx_q] != ST_M)));

  a_r6_silent_write: assert property (@(posedge clk) disable iff (!rst_n)
    (gany && (cur_op == OP_NONE) && req_wr_i[gidx]) |=> (st_q[$past(gidx)] == ST_M));
endmodule

// File: tb/mesif_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesif_line_ctrl_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [N-1:0] req_vld, req_wr, inv_ack;
  logic [N-1:0] grant, supply, wb, inv;
  logic [1:0] bus_op;
  logic mem_supply, busy;
  logic [3*N-1:0] state;

  mesif_line_ctrl #(.NCACHE(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld), .req_wr_i(req_wr),
    .inv_ack_i(inv_ack), .grant_o(grant), .bus_op_o(bus_op), .supply_o(supply),
    .mem_supply_o(mem_supply), .wb_o(wb), .inv_o(inv), .busy_o(busy), .state_o(state)
  );

  int errs = 0, checks = 0;
  logic [2:0] m [N];   // reference model: I=0 S=1 E=2 M=3 F=4

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic chk_states(input string r);
    for (int k = 0; k < N; k++) chk(r, $sformatf("state[%0d]", k), int'(state[k*3 +: 3]), int'(m[k]));
  endtask

  task automatic predict(input int c, input bit wr, output logic [1:0] op,
                         output logic [N-1:0] sp, output logic [N-1:0] w,
                         output logic [N-1:0] iv, output logic mem);
    sp = '0; w = '0; iv = '0;
    if (!wr) op = (m[c] == 0) ? 2'd1 : 2'd0;
    else if (m[c] == 3 || m[c] == 2) op = 2'd0;
    else op = (m[c] == 0) ? 2'd2 : 2'd3;
    for (int k = 0; k < N; k++) begin
      if (k == c) continue;
      if (op == 1 && (m[k] == 2 || m[k] == 3 || m[k] == 4)) begin sp[k] = 1; w[k] = (m[k] == 3); end
      if (op >= 2 && m[k] != 0) begin iv[k] = 1; w[k] = (m[k] == 3); end
    end
    mem = (op == 1) && (sp == '0);
  endtask

  task automatic commit(input int c, input bit wr, input logic [1:0] op, input logic [N-1:0] iv);
    bit others = 0;
    for (int k = 0; k < N; k++) if (k != c && m[k] != 0) others = 1;
    if (op == 1) begin
      for (int k = 0; k < N; k++) if (k != c && (m[k] == 2 || m[k] == 3 || m[k] == 4)) m[k] = 1;
      m[c] = others ? 3'd4 : 3'd2;
    end else if (op >= 2) begin
      for (int k = 0; k < N; k++) if (iv[k]) m[k] = 0;
      if (iv == '0) m[c] = 3;
    end else if (wr) m[c] = 3;
  endtask

  task automatic chk_outs(input string r, input int c, input logic [1:0] op, input logic [N-1:0] sp,
                          input logic [N-1:0] w, input logic [N-1:0] iv, input logic mem);
    chk(r, "grant", int'(grant), 1 << c);
    chk(r, "bus_op", int'(bus_op), int'(op));
    chk(r, "supply", int'(supply), int'(sp));
    chk(r, "mem_supply", int'(mem_supply), int'(mem));
    chk(r, "wb", int'(wb), int'(w));
    chk(r, "inv", int'(inv), int'(iv));
  endtask

  // One complete request, including a stray ack and ordered acks when invalidating.
  task automatic issue(input int c, input bit wr, input string r);
    logic [1:0] op; logic [N-1:0] sp, w, iv; logic mem; logic [2:0] pre; int left;
    predict(c, wr, op, sp, w, iv, mem);
    @(posedge clk); #1;
    req_vld = N'(1 << c); req_wr = wr ? N'(1 << c) : '0;
    #1 chk_outs(r, c, op, sp, w, iv, mem);
    pre = m[c];
    @(posedge clk); #1;
    req_vld = '0; req_wr = '0;
    commit(c, wr, op, iv);
    chk_states(r);
    if (iv != '0) begin
      chk(r, "busy", int'(busy), 1);
      inv_ack = ~iv;                       // acks from non-targets: ignored (R7)
      @(posedge clk); #1 inv_ack = '0;
      chk("R7", "stray ack busy", int'(busy), 1);
      chk("R7", "stray ack writer", int'(state[c*3 +: 3]), int'(pre));
      left = $countones(iv);
      for (int k = 0; k < N; k++) begin
        if (!iv[k]) continue;
        inv_ack = N'(1 << k);
        @(posedge clk); #1 inv_ack = '0;
        left--;
        chk(r, "busy after ack", int'(busy), left != 0);
        chk(r, "writer after ack", int'(state[c*3 +: 3]), left != 0 ? int'(pre) : 3);
      end
      m[c] = 3;
      chk_states(r);
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "grant", int'(grant), 0);
    chk_states("R1");
  endtask

  task automatic t_arb();     // R9: cores 1 and 2 read together
    logic [1:0] op; logic [N-1:0] sp, w, iv; logic mem;
    predict(1, 0, op, sp, w, iv, mem);
    @(posedge clk); #1 req_vld = 4'b0110; req_wr = '0;
    #1 chk_outs("R9", 1, op, sp, w, iv, mem);
    @(posedge clk); #1 req_vld = 4'b0100;
    commit(1, 0, op, iv);
    predict(2, 0, op, sp, w, iv, mem);
    #1 chk_outs("R9", 2, op, sp, w, iv, mem);
    @(posedge clk); #1 req_vld = '0;
    commit(2, 0, op, iv);
    chk_states("R9");
  endtask

  task automatic t_block();   // R9: request held off while invalidation pending
    logic [1:0] op; logic [N-1:0] sp, w, iv; logic mem;
    predict(0, 1, op, sp, w, iv, mem);
    @(posedge clk); #1 req_vld = 4'b0011; req_wr = 4'b0001;
    #1 chk_outs("R8", 0, op, sp, w, iv, mem);
    @(posedge clk); #1 req_vld = 4'b0010; req_wr = '0;
    commit(0, 1, op, iv);
    #1 chk("R9", "grant while busy", int'(grant), 0);
    chk("R9", "busy", int'(busy), 1);
    inv_ack = iv;
    @(posedge clk); #1 inv_ack = '0;
    m[0] = 3;
    chk_states("R8");
    predict(1, 0, op, sp, w, iv, mem);
    #1 chk_outs("R9", 1, op, sp, w, iv, mem);
    @(posedge clk); #1 req_vld = '0;
    commit(1, 0, op, iv);
    chk_states("R4");
  endtask

  initial begin
    #1000000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) m[k] = 0;
    rst_n = 0; req_vld = '0; req_wr = '0; inv_ack = '0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1;
    issue(0, 0, "R2");        // cold read -> E, memory supplies
    issue(0, 0, "R10");       // read hit
    issue(0, 1, "R6");        // E -> M silently
    issue(0, 1, "R6");        // M write, no traffic
    issue(1, 0, "R4");        // M owner writes back, supplies; 0 S, 1 F
    issue(2, 0, "R3");        // F moves to cache 2, cache 1 -> S (R5)
    issue(3, 0, "R3");        // F moves to cache 3
    issue(1, 0, "R10");       // read hit in S
    issue(0, 1, "R7");        // upgrade from S, invalidate 1,2,3
    issue(3, 1, "R8");        // write miss against M at 0
    t_arb();
    t_block();
    issue(2, 1, "R8");        // write miss, sharers 0 and 1
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule